// File: doc/BRIEF.md
# Clear-on-Read Interrupt Flag Register

This block is the interrupt identification register of a message-bus controller. It holds five sticky event flags: receive, transmit, error, overrun and wake-up. Each flag is set by its own qualified hardware event, and all of them are gathered into a single interrupt request line to the CPU. The block watches raw status levels from the rest of the controller and turns them into events. It sees a rise of the transmit-buffer release status, any change of the error or bus status bits, and the exit from sleep mode. It also combines the occupancy of the two receive buffers with a store request for an accepted message, which yields the overrun event.

The CPU sees the flags through an 8-bit read port. The current flags are always presented on the read data. A read strobe marks the cycle in which the CPU takes the value, and at the next clock edge every flag is cleared, unless a fresh event arrives in that same cycle. The register has no write path.

Top module: `irq_flag_reg`

## Requirements
- R1: The read data carries receive at bit 0, transmit at bit 1, error at bit 2, overrun at bit 3 and wake-up at bit 4. Bits 7 to 5 always read 0.
- R2: `irq` is high exactly when at least one of the five flags is set.
- R3: While `rd_stb` is high, `rd_data` shows the flags as they stand before the clear. At the clock edge that ends the strobe cycle, every flag without a new event drops to 0.
- R4: If a flag's event occurs in the same cycle as a read strobe, that flag is 1 after the edge.
- R5: With `rx_en` high, a pulse on `rx_msg_new` sets the receive flag at the same clock edge. With `rx_en` low, the pulse has no effect.
- R6: With `tx_en` high, a 0-to-1 transition of `tx_access` sets the transmit flag. A 1-to-0 transition, a steady level, or any transition while `tx_en` is low, does not set it.
- R7: With `err_en` high, any change of `err_stat` or of `bus_stat`, in either direction, sets the error flag. With `err_en` low, such changes have no effect.
- R8: The overrun flag sets only when `ovr_en`, `rxbuf0_full`, `rxbuf1_full` and `store_first` are all high in the same cycle.
- R9: A 1-to-0 transition of `sleep_mode` sets the wake-up flag whatever the enables are. A 0-to-1 transition does not set it.
- R10: During and right after reset all flags are 0. Input levels that are present while reset is held produce no event when reset is released.
- R11: A set flag holds its value until a read strobe clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive flag enable |
| tx_en | input | 1 | Transmit flag enable |
| err_en | input | 1 | Error flag enable |
| ovr_en | input | 1 | Overrun flag enable |
| rx_msg_new | input | 1 | Pulse: new message available in receive buffer |
| tx_access | input | 1 | Transmit-buffer release status level |
| err_stat | input | 1 | Error status level |
| bus_stat | input | 1 | Bus status level |
| sleep_mode | input | 1 | Sleep mode level |
| rxbuf0_full | input | 1 | First receive buffer holds a message |
| rxbuf1_full | input | 1 | Second receive buffer holds a message |
| store_first | input | 1 | First byte of an accepted message is being stored |
| rd_stb | input | 1 | CPU read strobe for the register |
| rd_data | output | 8 | Register contents |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
Each flag is tested with its trigger and with the near-miss patterns beside it. For transmit, a falling edge and a held level are applied next to the rising edge. For wake-up, sleep entry is applied next to sleep exit. For error, changes on each status bit are applied separately, and for overrun, one full buffer is applied next to two full buffers. Each trigger is also repeated with its enable low. Together these separate the edge polarity, the any-change rule and the full AND condition from looser decodes. Several flags are fired at once to confirm the bit positions. An event placed in the strobe cycle shows whether the set wins over the clear. Reset is held with nonzero status levels to expose false events at release.

// File: rtl/irqreg_pkg.sv
package irqreg_pkg;

    localparam int REG_W   = 8;
    localparam int NFLAG   = 5;
    localparam int PAD_W   = REG_W - NFLAG;

    localparam int BIT_RX   = 0;
    localparam int BIT_TX   = 1;
    localparam int BIT_ERR  = 2;
    localparam int BIT_OVR  = 3;
    localparam int BIT_WAKE = 4;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_ANY  = 2'd2
    } edge_kind_e;

    // Packed order puts wake at bit 4 down to rx at bit 0.
    typedef struct packed {
        logic wake;
        logic ovr;
        logic err;
        logic tx;
        logic rx;
    } flag_vec_t;

    typedef struct packed {
        logic rx;
        logic tx;
        logic err;
        logic ovr;
    } enable_t;

    function automatic logic [REG_W-1:0] pack_reg(input flag_vec_t f);
        return {{PAD_W{1'b0}}, f};
    endfunction

endpackage

// File: rtl/edge_track.sv
module edge_track
    import irqreg_pkg::*;
#(
    parameter int         WIDTH = 1,
    parameter edge_kind_e KIND  = EDGE_ANY
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] sig,
    output logic             evt
);

    logic [WIDTH-1:0] sig_q;
    logic [WIDTH-1:0] hit;

    // Reset loads the live level so that release sees no step.
    always_ff @(posedge clk) begin
        sig_q <= sig;
    end

    generate
        if (KIND == EDGE_RISE) begin : g_rise
            assign hit = sig & ~sig_q;
        end else if (KIND == EDGE_FALL) begin : g_fall
            assign hit = ~sig & sig_q;
        end else begin : g_any
            assign hit = sig ^ sig_q;
        end
    endgenerate

    assign evt = (|hit) & ~rst;

endmodule

// File: rtl/event_qualify.sv
module event_qualify
    import irqreg_pkg::*;
(
    input  enable_t   en,
    input  logic      rx_msg_new,
    input  logic      tx_rise,
    input  logic      stat_change,
    input  logic      sleep_exit,
    input  logic      rxbuf0_full,
    input  logic      rxbuf1_full,
    input  logic      store_first,
    output flag_vec_t set_vec
);

    logic both_full;

    assign both_full = rxbuf0_full & rxbuf1_full;

    always_comb begin
        set_vec      = '0;
        set_vec.rx   = en.rx  & rx_msg_new;
        set_vec.tx   = en.tx  & tx_rise;
        set_vec.err  = en.err & stat_change;
        set_vec.ovr  = en.ovr & both_full & store_first;
        set_vec.wake = sleep_exit;
    end

endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] q
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)
                    q[i] <= 1'b0;
                else if (set[i])
                    q[i] <= 1'b1;
                else if (clr)
                    q[i] <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irqreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic             err_en,
    input  logic             ovr_en,
    input  logic             rx_msg_new,
    input  logic             tx_access,
    input  logic             err_stat,
    input  logic             bus_stat,
    input  logic             sleep_mode,
    input  logic             rxbuf0_full,
    input  logic             rxbuf1_full,
    input  logic             store_first,
    input  logic             rd_stb,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);

    logic      tx_rise;
    logic      stat_change;
    logic      sleep_exit;
    enable_t   en;
    flag_vec_t set_vec;
    flag_vec_t flags;

    assign en = '{rx: rx_en, tx: tx_en, err: err_en, ovr: ovr_en};

    edge_track #(.WIDTH(1), .KIND(EDGE_RISE)) u_tx_edge (
        .clk (clk),
        .rst (rst),
        .sig (tx_access),
        .evt (tx_rise)
    );

    edge_track #(.WIDTH(2), .KIND(EDGE_ANY)) u_stat_edge (
        .clk (clk),
        .rst (rst),
        .sig ({bus_stat, err_stat}),
        .evt (stat_change)
    );

    edge_track #(.WIDTH(1), .KIND(EDGE_FALL)) u_sleep_edge (
        .clk (clk),
        .rst (rst),
        .sig (sleep_mode),
        .evt (sleep_exit)
    );

    event_qualify u_qual (
        .en          (en),
        .rx_msg_new  (rx_msg_new),
        .tx_rise     (tx_rise),
        .stat_change (stat_change),
        .sleep_exit  (sleep_exit),
        .rxbuf0_full (rxbuf0_full),
        .rxbuf1_full (rxbuf1_full),
        .store_first (store_first),
        .set_vec     (set_vec)
    );

    flag_bank #(.N(NFLAG)) u_bank (
        .clk (clk),
        .rst (rst),
        .set (set_vec),
        .clr (rd_stb),
        .q   (flags)
    );

    assign rd_data = pack_reg(flags);
    assign irq     = |flags;

endmodule

// File: rtl/irq_flag_reg_chk.sv
module irq_flag_reg_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_stb,
    input logic [7:0] rd_data,
    input logic       irq,
    input logic [4:0] flag_set,
    input logic       tx_en,
    input logic       tx_access,
    input logic       err_en,
    input logic       err_stat,
    input logic       bus_stat,
    input logic       sleep_mode,
    input logic       ovr_en,
    input logic       rxbuf0_full,
    input logic       rxbuf1_full,
    input logic       store_first
);

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:5] == 3'b000);

    // R2
    irq_any_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (rd_data[4:0] != 5'd0));

    // R3
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> (rd_data[4:0] == $past(flag_set)));

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb && rd_data[0]) |=> rd_data[0]);

    // R6
    tx_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_en && $rose(tx_access)) |=> rd_data[1]);

    // R7
    err_change_chk: assert property (@(posedge clk) disable iff (rst)
        (err_en && (!$stable(err_stat) || !$stable(bus_stat))) |=> rd_data[2]);

    // R8
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_en && rxbuf0_full && rxbuf1_full && store_first) |=> rd_data[3]);

    // R9
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep_mode) |=> rd_data[4]);

endmodule

bind irq_flag_reg irq_flag_reg_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_stb      (rd_stb),
    .rd_data     (rd_data),
    .irq         (irq),
    .flag_set    (set_vec),
    .tx_en       (tx_en),
    .tx_access   (tx_access),
    .err_en      (err_en),
    .err_stat    (err_stat),
    .bus_stat    (bus_stat),
    .sleep_mode  (sleep_mode),
    .ovr_en      (ovr_en),
    .rxbuf0_full (rxbuf0_full),
    .rxbuf1_full (rxbuf1_full),
    .store_first (store_first)
);

// File: tb/irq_flag_reg_tb.sv
module irq_flag_reg_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 0, tx_en = 0, err_en = 0, ovr_en = 0;
    logic       rx_msg_new = 0, tx_access = 0, err_stat = 0, bus_stat = 0;
    logic       sleep_mode = 0, rxbuf0_full = 0, rxbuf1_full = 0, store_first = 0;
    logic       rd_stb = 0;
    logic [7:0] rd_data;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_flag_reg u_dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .tx_en(tx_en), .err_en(err_en),
        .ovr_en(ovr_en), .rx_msg_new(rx_msg_new), .tx_access(tx_access),
        .err_stat(err_stat), .bus_stat(bus_stat), .sleep_mode(sleep_mode),
        .rxbuf0_full(rxbuf0_full), .rxbuf1_full(rxbuf1_full),
        .store_first(store_first), .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic read_clear(input string req, input logic [7:0] exp);
        rd_stb = 1'b1;
        chk(req, rd_data, exp);
        step();
        rd_stb = 1'b0;
        chk({req, " cleared"}, rd_data, 8'h00);
    endtask

    // R10: status levels held high through reset produce no event
    task automatic t_reset;
        tx_access = 1; err_stat = 1; sleep_mode = 1;
        rx_en = 1; tx_en = 1; err_en = 1; ovr_en = 1;
        rst = 1;
        step(3);
        rst = 0;
        step(2);
        chk("R10 flags after reset", rd_data, 8'h00);
        chk("R10 irq after reset", {7'd0, irq}, 8'h00);
    endtask

    // R5, R11, R2, R3
    task automatic t_rx;
        rx_en = 1; rx_msg_new = 1; step(); rx_msg_new = 0;
        chk("R5 rx flag", rd_data, 8'h01);
        chk("R2 irq high", {7'd0, irq}, 8'h01);
        step(3);
        chk("R11 rx flag held", rd_data, 8'h01);
        read_clear("R3 rx read", 8'h01);
        chk("R2 irq low", {7'd0, irq}, 8'h00);
        rx_en = 0; rx_msg_new = 1; step(); rx_msg_new = 0;
        chk("R5 rx disabled", rd_data, 8'h00);
    endtask

    // R6
    task automatic t_tx;
        tx_en = 1;
        tx_access = 0; step();
        chk("R6 tx falling no set", rd_data, 8'h00);
        tx_access = 1; step();
        chk("R6 tx rising sets", rd_data, 8'h02);
        read_clear("R3 tx read", 8'h02);
        step(2);
        chk("R6 tx steady high no set", rd_data, 8'h00);
        tx_en = 0; tx_access = 0; step(); tx_access = 1; step();
        chk("R6 tx disabled", rd_data, 8'h00);
    endtask

    // R7
    task automatic t_err;
        err_en = 1;
        err_stat = 0; step();
        chk("R7 err_stat fall sets", rd_data, 8'h04);
        read_clear("R7 err read", 8'h04);
        bus_stat = 1; step();
        chk("R7 bus_stat rise sets", rd_data, 8'h04);
        read_clear("R7 bus read", 8'h04);
        err_en = 0; bus_stat = 0; step(); err_stat = 1; step();
        chk("R7 err disabled", rd_data, 8'h00);
    endtask

    // R8
    task automatic t_ovr;
        ovr_en = 1; rxbuf0_full = 1; rxbuf1_full = 1; store_first = 1; step();
        store_first = 0;
        chk("R8 overrun sets", rd_data, 8'h08);
        read_clear("R8 overrun read", 8'h08);
        rxbuf1_full = 0; store_first = 1; step(); store_first = 0;
        chk("R8 one buffer no set", rd_data, 8'h00);
        rxbuf1_full = 1; rxbuf0_full = 0; store_first = 1; step(); store_first = 0;
        chk("R8 other buffer no set", rd_data, 8'h00);
        rxbuf0_full = 1; step();
        chk("R8 no store no set", rd_data, 8'h00);
        ovr_en = 0; store_first = 1; step(); store_first = 0;
        chk("R8 overrun disabled", rd_data, 8'h00);
        rxbuf0_full = 0; rxbuf1_full = 0;
    endtask

    // R9
    task automatic t_wake;
        rx_en = 0; tx_en = 0; err_en = 0; ovr_en = 0;
        sleep_mode = 0; step();
        chk("R9 wake on sleep exit", rd_data, 8'h10);
        read_clear("R9 wake read", 8'h10);
        sleep_mode = 1; step();
        chk("R9 sleep entry no set", rd_data, 8'h00);
    endtask

    // R1: several flags together
    task automatic t_multi;
        rx_en = 1; tx_en = 1; err_en = 1;
        tx_access = 0; step();
        rx_msg_new = 1; tx_access = 1; bus_stat = 1; sleep_mode = 0; step();
        rx_msg_new = 0;
        chk("R1 bit layout", rd_data, 8'h17);
        read_clear("R1 layout read", 8'h17);
    endtask

    // R4
    task automatic t_collide;
        rx_msg_new = 1; step(); rx_msg_new = 0;
        tx_access = 0; step();
        rd_stb = 1; tx_access = 1;
        chk("R4 read shows pre-clear", rd_data, 8'h01);
        step(); rd_stb = 0;
        chk("R4 event during read kept", rd_data, 8'h02);
        read_clear("R4 final read", 8'h02);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_rx();
        t_tx();
        t_err();
        t_ovr();
        t_wake();
        t_multi();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule